// File: doc/BRIEF.md
# Shared Byte FIFO with Word Packing

This block is one byte-wide storage array that an SPI channel uses as a transmit queue, a receive queue, or both at once. Words of 4 to 32 bits are written in through a push port and read out through a pop port. Each word is split into whole bytes, least-significant byte first, so a 12-bit word takes two byte slots and a 32-bit word takes four.

The capacity of each direction follows the two direction enables. With one direction enabled, that direction owns the whole array and the other has no room. With both enabled, the array is split into two equal halves: the transmit half sits at the low addresses and the receive half at the high addresses. A synchronous flush empties both queues and returns both read positions to the start. The owning channel logic raises the flush whenever the enables, the threshold setting or the channel enable change. Thresholds, DMA requests and interrupts are handled outside the block, which only exports fill levels and full/empty flags.

Top module: `shared_byte_fifo`

## Requirements
- R1: After a synchronous active-low reset, both fill levels are 0 and both empty flags are 1.
- R2: Direction capacity is 64 bytes when only that direction is enabled, 32 bytes when both are enabled, and 0 when it is disabled. A full flag is 1 exactly when the level equals the capacity, so a direction with zero capacity reads as full and empty at once.
- R3: The word length in bits is the 5-bit length field plus one. A push stores ceil(length/8) bytes. A direction that is neither pushed nor popped keeps its level.
- R4: A push stores its bytes in order from bits 7:0 upward. When the queue becomes full partway through a word, the remaining bytes are discarded, the level stops at the capacity, and bytes already queued are unchanged.
- R5: A pop returns ceil(length/8) bytes, with the oldest byte placed at bits 7:0 and each later byte at the next 8-bit lane.
- R6: When fewer bytes are queued than the pop asks for, only the queued bytes are returned and every missing lane reads 0. A pop on an empty queue returns 0 and leaves the level at 0.
- R7: Read and write positions wrap at the current capacity, so byte order is kept across the wrap point.
- R8: A push to a direction with zero capacity has no effect: its level stays 0.
- R9: With both directions enabled, the two halves are independent. Traffic in one direction neither changes the level nor alters the data of the other.
- R10: A push and a pop on the same direction in the same cycle change the level by the net byte count. The pop returns data that was queued before that cycle.
- R11: Flush sets both levels to 0 on the next edge and takes priority over any push or pop in the same cycle. Data pushed after a flush is popped back unchanged.
- R12: pop_word is valid in the same cycle that pop_req is high. The level changes on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| flush | input | 1 | Empty both queues and reset their read positions |
| push_req | input | 1 | Push a word this cycle |
| push_dir | input | 1 | Push target: 0 transmit, 1 receive |
| push_word | input | 32 | Word to push |
| push_wl | input | 5 | Push word length minus one, in bits |
| pop_req | input | 1 | Pop a word this cycle |
| pop_dir | input | 1 | Pop source: 0 transmit, 1 receive |
| pop_wl | input | 5 | Pop word length minus one, in bits |
| pop_word | output | 32 | Popped word, zero-filled where no byte was queued |
| tx_level | output | 7 | Transmit fill level in bytes |
| rx_level | output | 7 | Receive fill level in bytes |
| tx_full | output | 1 | Transmit level equals transmit capacity |
| tx_empty | output | 1 | Transmit level is zero |
| rx_full | output | 1 | Receive level equals receive capacity |
| rx_empty | output | 1 | Receive level is zero |

## Verification
The level bound on each direction holds only if every change of the direction enables is accompanied by a flush, because the capacity switches at once and the stored counts are not clipped. For that reason the checker tests the bound only while the enables have been stable since the last flush. The bench changes the enables only through one task that raises flush in the same cycle. The remaining properties assume nothing about the inputs, so the stimulus may freely overfill, underflow, and push and pop on the same cycle.

// File: rtl/sbf_pkg.sv
// Package for the shared byte FIFO.
// Holds the direction codes used by the push and pop selectors.
// Assumes nothing beyond a single 1-bit direction select.
package sbf_pkg;
    localparam int unsigned DIR_COUNT = 2;
    localparam logic        DIR_TX    = 1'b0;
    localparam logic        DIR_RX    = 1'b1;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/sbf_dir_ctrl.sv
// Per-direction queue state: start offset and byte count.
// Grants as many requested bytes as space (push) or content (pop) allow,
// and gives the wrapped offsets of each byte lane inside the region.
// Assumes start < cap and len <= cap, which holds while every capacity
// change comes with a flush.
module sbf_dir_ctrl #(
    parameter  int DEPTH = 64,
    parameter  int LANES = 4,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int NB_W  = $clog2(LANES + 1),
    localparam int SUM_W = LVL_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [LVL_W-1:0]             cap,
    input  logic [NB_W-1:0]              push_nb,
    input  logic [NB_W-1:0]              pop_nb,
    output logic [LVL_W-1:0]             level,
    output logic [NB_W-1:0]              n_push,
    output logic [NB_W-1:0]              n_pop,
    output logic [LANES-1:0][IDX_W-1:0]  rd_off,
    output logic [LANES-1:0][IDX_W-1:0]  wr_off
);
    logic [IDX_W-1:0] start_q;
    logic [LVL_W-1:0] len_q;
    logic [LVL_W-1:0] space;

    // Reduce a position that is below twice the capacity into the region.
    function automatic logic [IDX_W-1:0] wrap(input logic [SUM_W-1:0] p,
                                              input logic [LVL_W-1:0] c);
        if (p >= SUM_W'(c)) return IDX_W'(p - SUM_W'(c));
        return IDX_W'(p);
    endfunction

    // Clip the requests to the free space and to the queued bytes.
    always_comb begin
        space = (cap > len_q) ? cap - len_q : '0;
        if (LVL_W'(push_nb) > space) n_push = NB_W'(space);
        else                         n_push = push_nb;
        if (LVL_W'(pop_nb) > len_q)  n_pop  = NB_W'(len_q);
        else                         n_pop  = pop_nb;
    end

    // Lane offsets for reading (from start) and writing (after the tail).
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign rd_off[gi] = wrap(SUM_W'(start_q) + SUM_W'(gi), cap);
        assign wr_off[gi] = wrap(SUM_W'(start_q) + SUM_W'(len_q) + SUM_W'(gi), cap);
    end

    // Move start past the popped bytes and update the count by the net change.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            start_q <= '0;
            len_q   <= '0;
        end else begin
            start_q <= wrap(SUM_W'(start_q) + SUM_W'(n_pop), cap);
            len_q   <= len_q + LVL_W'(n_push) - LVL_W'(n_pop);
        end
    end

    assign level = len_q;
endmodule

// File: rtl/sbf_byte_store.sv
// Byte-wide storage array with one write and one read per byte lane.
// Reads are combinational and writes take effect on the clock edge.
// Assumes the enabled write lanes address distinct bytes and that
// DEPTH is a power of two.
module sbf_byte_store #(
    parameter  int DEPTH = 64,
    parameter  int LANES = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             we,
    input  logic [LANES-1:0][IDX_W-1:0]  waddr,
    input  logic [LANES-1:0][7:0]        wdata,
    input  logic [LANES-1:0][IDX_W-1:0]  raddr,
    output logic [LANES-1:0][7:0]        rdata
);
    sbf_pkg::byte_t mem [DEPTH];

    // Clear the array on reset and store each enabled lane afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (we[l]) mem[waddr[l]] <= wdata[l];
        end
    end

    // Give every lane its own read port.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_rd
        assign rdata[gi] = mem[raddr[gi]];
    end
endmodule

// File: rtl/shared_byte_fifo.sv
// Shared byte FIFO: one byte array split between a transmit and a receive
// queue according to the direction enables. Words are packed into bytes
// least-significant first. Pushes that overflow and pops that underflow
// are truncated at the byte boundary.
// Assumes the caller flushes whenever the enables change.
module shared_byte_fifo #(
    parameter  int DEPTH_BYTES = 64,
    parameter  int WORD_MAX    = 32,
    localparam int LANES = WORD_MAX / 8,
    localparam int HALF  = DEPTH_BYTES / 2,
    localparam int LVL_W = $clog2(DEPTH_BYTES + 1),
    localparam int IDX_W = $clog2(DEPTH_BYTES),
    localparam int NB_W  = $clog2(LANES + 1),
    localparam int WL_W  = $clog2(WORD_MAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 flush,
    input  logic                 push_req,
    input  logic                 push_dir,
    input  logic [WORD_MAX-1:0]  push_word,
    input  logic [WL_W-1:0]      push_wl,
    input  logic                 pop_req,
    input  logic                 pop_dir,
    input  logic [WL_W-1:0]      pop_wl,
    output logic [WORD_MAX-1:0]  pop_word,
    output logic [LVL_W-1:0]     tx_level,
    output logic [LVL_W-1:0]     rx_level,
    output logic                 tx_full,
    output logic                 tx_empty,
    output logic                 rx_full,
    output logic                 rx_empty
);
    import sbf_pkg::*;

    logic [LVL_W-1:0]            cap     [DIR_COUNT];
    logic [IDX_W-1:0]            base    [DIR_COUNT];
    logic [NB_W-1:0]             req_push[DIR_COUNT];
    logic [NB_W-1:0]             req_pop [DIR_COUNT];
    logic [LVL_W-1:0]            level   [DIR_COUNT];
    logic [NB_W-1:0]             n_push  [DIR_COUNT];
    logic [NB_W-1:0]             n_pop   [DIR_COUNT];
    logic [LANES-1:0][IDX_W-1:0] rd_off  [DIR_COUNT];
    logic [LANES-1:0][IDX_W-1:0] wr_off  [DIR_COUNT];

    logic [LANES-1:0]            we;
    logic [LANES-1:0][IDX_W-1:0] waddr;
    logic [LANES-1:0][7:0]       wdata;
    logic [LANES-1:0][IDX_W-1:0] raddr;
    logic [LANES-1:0][7:0]       rdata;
    logic [NB_W-1:0]             push_bytes;
    logic [NB_W-1:0]             pop_bytes;

    // Number of whole bytes covering a word of wl+1 bits.
    function automatic logic [NB_W-1:0] nbytes(input logic [WL_W-1:0] wl);
        logic [WL_W+1:0] t;
        t = {2'b00, wl} + (WL_W+2)'(8);
        return NB_W'(t >> 3);
    endfunction

    // Capacity and base address of each region, taken from the enables.
    always_comb begin
        cap[DIR_TX]  = tx_en ? (rx_en ? LVL_W'(HALF) : LVL_W'(DEPTH_BYTES)) : '0;
        cap[DIR_RX]  = rx_en ? (tx_en ? LVL_W'(HALF) : LVL_W'(DEPTH_BYTES)) : '0;
        base[DIR_TX] = '0;
        base[DIR_RX] = tx_en ? IDX_W'(HALF) : '0;
    end

    assign push_bytes = nbytes(push_wl);
    assign pop_bytes  = nbytes(pop_wl);

    // One state controller per direction; requests are steered by direction.
    for (genvar d = 0; d < DIR_COUNT; d++) begin : g_dir
        assign req_push[d] = (push_req && !flush && (push_dir == 1'(d))) ? push_bytes : '0;
        assign req_pop[d]  = (pop_req  && !flush && (pop_dir  == 1'(d))) ? pop_bytes  : '0;

        sbf_dir_ctrl #(.DEPTH(DEPTH_BYTES), .LANES(LANES)) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .cap     (cap[d]),
            .push_nb (req_push[d]),
            .pop_nb  (req_pop[d]),
            .level   (level[d]),
            .n_push  (n_push[d]),
            .n_pop   (n_pop[d]),
            .rd_off  (rd_off[d]),
            .wr_off  (wr_off[d])
        );
    end

    // Map the byte lanes onto array addresses and assemble the popped word.
    for (genvar l = 0; l < LANES; l++) begin : g_map
        assign we[l]    = (NB_W'(l) < n_push[push_dir]);
        assign waddr[l] = base[push_dir] + wr_off[push_dir][l];
        assign wdata[l] = push_word[8*l +: 8];
        assign raddr[l] = base[pop_dir] + rd_off[pop_dir][l];
        assign pop_word[8*l +: 8] = (NB_W'(l) < n_pop[pop_dir]) ? rdata[l] : 8'h00;
    end

    sbf_byte_store #(.DEPTH(DEPTH_BYTES), .LANES(LANES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign tx_level = level[DIR_TX];
    assign rx_level = level[DIR_RX];
    assign tx_full  = (level[DIR_TX] == cap[DIR_TX]);
    assign rx_full  = (level[DIR_RX] == cap[DIR_RX]);
    assign tx_empty = (level[DIR_TX] == '0);
    assign rx_empty = (level[DIR_RX] == '0);
endmodule

// File: rtl/shared_byte_fifo_chk.sv
// Assertion checker for the shared byte FIFO, bound to the top module.
// Tracks whether the enables have stayed the same since the last flush,
// so that the capacity bound is checked only when it can hold.
module shared_byte_fifo_chk #(
    parameter  int DEPTH_BYTES = 64,
    parameter  int WORD_MAX    = 32,
    localparam int LANES = WORD_MAX / 8,
    localparam int LVL_W = $clog2(DEPTH_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                flush,
    input  logic                push_req,
    input  logic                push_dir,
    input  logic                pop_req,
    input  logic                pop_dir,
    input  logic [WORD_MAX-1:0] pop_word,
    input  logic [LVL_W-1:0]    tx_level,
    input  logic [LVL_W-1:0]    rx_level,
    input  logic                tx_empty,
    input  logic                rx_empty
);
    logic [1:0]       en_q;
    logic             cfg_ok_q;
    logic [LVL_W-1:0] cap_tx;
    logic [LVL_W-1:0] cap_rx;
    logic             push_tx, push_rx, pop_tx, pop_rx;

    // Record the enables and whether a flush followed their last change.
    always_ff @(posedge clk) begin
        en_q <= {tx_en, rx_en};
        if (!rst_n || flush)            cfg_ok_q <= 1'b1;
        else if ({tx_en, rx_en} != en_q) cfg_ok_q <= 1'b0;
    end

    // Capacity worked out again from the requirement.
    always_comb begin
        cap_tx = !tx_en ? '0 : (rx_en ? LVL_W'(DEPTH_BYTES / 2) : LVL_W'(DEPTH_BYTES));
        cap_rx = !rx_en ? '0 : (tx_en ? LVL_W'(DEPTH_BYTES / 2) : LVL_W'(DEPTH_BYTES));
    end

    assign push_tx = push_req && !push_dir;
    assign push_rx = push_req &&  push_dir;
    assign pop_tx  = pop_req  && !pop_dir;
    assign pop_rx  = pop_req  &&  pop_dir;

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok_q && ({tx_en, rx_en} == en_q)) |-> (tx_level <= cap_tx && rx_level <= cap_rx)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0 && rx_level == '0)); // R11
    AST_TX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !push_tx && !pop_tx) |=> $stable(tx_level)); // R3
    AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !push_rx && !pop_rx) |=> $stable(rx_level)); // R3
    AST_TX_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push_tx && !pop_tx) |=> (tx_level >= $past(tx_level) &&
            {1'b0, tx_level} <= {1'b0, $past(tx_level)} + (LVL_W+1)'(LANES))); // R4
    AST_TX_POP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && pop_tx && !push_tx) |=> tx_level <= $past(tx_level)); // R6
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (pop_dir ? rx_empty : tx_empty)) |-> pop_word == '0); // R6
    AST_ZERO_CAP_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && tx_level == '0) |=> tx_level == '0); // R8
    AST_ZERO_CAP_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && rx_level == '0) |=> rx_level == '0); // R8
endmodule

bind shared_byte_fifo shared_byte_fifo_chk #(
    .DEPTH_BYTES (DEPTH_BYTES),
    .WORD_MAX    (WORD_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .flush    (flush),
    .push_req (push_req),
    .push_dir (push_dir),
    .pop_req  (pop_req),
    .pop_dir  (pop_dir),
    .pop_word (pop_word),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_empty (tx_empty),
    .rx_empty (rx_empty)
);

// File: tb/shared_byte_fifo_tb.sv
// Directed bench for the shared byte FIFO. Each task drives one scenario
// and checks its own results. Inputs change on the falling edge, pop data
// is sampled before the next rising edge, and levels after it.
module shared_byte_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b1, rx_en = 1'b0, flush = 1'b0;
    logic        push_req = 1'b0, push_dir = 1'b0, pop_req = 1'b0, pop_dir = 1'b0;
    logic [31:0] push_word = '0;
    logic [4:0]  push_wl = '0, pop_wl = '0;
    logic [31:0] pop_word;
    logic [6:0]  tx_level, rx_level;
    logic        tx_full, tx_empty, rx_full, rx_empty;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    shared_byte_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .flush(flush),
        .push_req(push_req), .push_dir(push_dir), .push_word(push_word), .push_wl(push_wl),
        .pop_req(pop_req), .pop_dir(pop_dir), .pop_wl(pop_wl), .pop_word(pop_word),
        .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One cycle with an optional push and pop; bits is the word length.
    task automatic op(input bit dp, input bit pd, input logic [31:0] w, input int pbits,
                      input bit dq, input bit qd, input int qbits, output logic [31:0] got);
        push_req = dp; push_dir = pd; push_word = w; push_wl = 5'(pbits - 1);
        pop_req  = dq; pop_dir  = qd; pop_wl  = 5'(qbits - 1);
        #5 got = pop_word;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
    endtask

    task automatic push(input bit d, input logic [31:0] w, input int bits);
        logic [31:0] g;
        op(1'b1, d, w, bits, 1'b0, 1'b0, 8, g);
    endtask

    task automatic pop(input bit d, input int bits, output logic [31:0] got);
        op(1'b0, 1'b0, '0, 8, 1'b1, d, bits, got);
    endtask

    // Change the enables together with a flush.
    task automatic set_mode(input bit t, input bit r);
        tx_en = t; rx_en = r; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tx_level", 32'(tx_level), 0);
        chk("R1 rx_level", 32'(rx_level), 0);
        chk("R1 empties", {30'd0, tx_empty, rx_empty}, 32'd3);
        chk("R2 zero-capacity rx reads full", 32'(rx_full), 1);
    endtask

    task automatic t_pack();
        logic [31:0] g;
        set_mode(1'b1, 1'b0);
        push(1'b0, 32'h44332211, 32);
        chk("R3 32-bit push is 4 bytes", 32'(tx_level), 4);
        push(1'b0, 32'h00000ABC, 12);
        chk("R3 12-bit push is 2 bytes", 32'(tx_level), 6);
        pop(1'b0, 32, g);
        chk("R5 R12 32-bit pop order", g, 32'h44332211);
        chk("R12 level after pop", 32'(tx_level), 2);
        pop(1'b0, 16, g);
        chk("R5 16-bit pop", g, 32'h00000ABC);
        push(1'b0, 32'h00000007, 4);
        chk("R3 4-bit push is 1 byte", 32'(tx_level), 1);
        pop(1'b0, 4, g);
        chk("R5 4-bit pop", g, 32'h7);
    endtask

    task automatic t_fill_tx();
        logic [31:0] g;
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 16; i++) push(1'b0, 32'hA0B0C0D0 + 32'(i), 32);
        chk("R2 tx-only capacity 64", 32'(tx_level), 64);
        chk("R2 tx full", 32'(tx_full), 1);
        push(1'b0, 32'hFFFFFFFF, 32);
        chk("R4 push when full dropped", 32'(tx_level), 64);
        for (int i = 0; i < 16; i++) begin
            pop(1'b0, 32, g);
            chk("R4 R7 full-queue order", g, 32'hA0B0C0D0 + 32'(i));
        end
        pop(1'b0, 32, g);
        chk("R6 pop on empty is zero", g, 32'h0);
        chk("R6 level stays zero", 32'(tx_level), 0);
    endtask

    task automatic t_wrap_both();
        logic [31:0] g;
        set_mode(1'b1, 1'b1);
        for (int i = 0; i < 8; i++) push(1'b0, 32'h11110000 + 32'(i), 32);
        chk("R2 shared capacity 32", 32'(tx_level), 32);
        chk("R2 tx full at 32", 32'(tx_full), 1);
        pop(1'b0, 32, g);
        chk("R7 first word", g, 32'h11110000);
        push(1'b0, 32'h99887766, 32);
        chk("R7 refill to 32", 32'(tx_level), 32);
        for (int i = 1; i < 8; i++) begin
            pop(1'b0, 32, g);
            chk("R7 order across wrap", g, 32'h11110000 + 32'(i));
        end
        pop(1'b0, 32, g);
        chk("R7 wrapped word", g, 32'h99887766);
        chk("R9 rx untouched", 32'(rx_level), 0);
    endtask

    task automatic t_partial();
        logic [31:0] g;
        set_mode(1'b1, 1'b1);
        for (int i = 0; i < 7; i++) push(1'b0, 32'h20000000 + 32'(i), 32);
        push(1'b0, 32'h00002211, 16);
        chk("R3 level 30", 32'(tx_level), 30);
        push(1'b0, 32'hDDCCBBAA, 32);
        chk("R4 partial push stops at capacity", 32'(tx_level), 32);
        for (int i = 0; i < 7; i++) begin
            pop(1'b0, 32, g);
            chk("R4 earlier data intact", g, 32'h20000000 + 32'(i));
        end
        pop(1'b0, 16, g);
        chk("R5 halfword", g, 32'h00002211);
        pop(1'b0, 32, g);
        chk("R6 partial pop zero-filled", g, 32'h0000BBAA);
        chk("R6 level zero after partial", 32'(tx_level), 0);
    endtask

    task automatic t_split();
        logic [31:0] g;
        set_mode(1'b1, 1'b1);
        push(1'b0, 32'hCAFEF00D, 32);
        push(1'b1, 32'h12345678, 32);
        chk("R9 tx level", 32'(tx_level), 4);
        chk("R9 rx level", 32'(rx_level), 4);
        pop(1'b1, 32, g);
        chk("R9 rx data", g, 32'h12345678);
        chk("R9 tx level unchanged", 32'(tx_level), 4);
        pop(1'b0, 32, g);
        chk("R9 tx data", g, 32'hCAFEF00D);
    endtask

    task automatic t_rx_only();
        logic [31:0] g;
        set_mode(1'b0, 1'b1);
        push(1'b0, 32'h01020304, 32);
        chk("R8 push to zero-capacity tx ignored", 32'(tx_level), 0);
        pop(1'b0, 32, g);
        chk("R8 pop from zero-capacity tx", g, 32'h0);
        push(1'b1, 32'h0000005A, 8);
        for (int i = 0; i < 16; i++) push(1'b1, 32'h30303030 + 32'(i), 32);
        chk("R2 rx-only capacity 64", 32'(rx_level), 64);
        chk("R2 rx full", 32'(rx_full), 1);
        pop(1'b1, 8, g);
        chk("R5 rx byte", g, 32'h5A);
    endtask

    task automatic t_same_cycle();
        logic [31:0] g;
        set_mode(1'b1, 1'b0);
        push(1'b0, 32'h01020304, 32);
        op(1'b1, 1'b0, 32'h0A0B0C0D, 32, 1'b1, 1'b0, 32, g);
        chk("R10 pop sees old word", g, 32'h01020304);
        chk("R10 net level", 32'(tx_level), 4);
        op(1'b1, 1'b0, 32'h000000EE, 8, 1'b1, 1'b0, 32, g);
        chk("R10 second pop", g, 32'h0A0B0C0D);
        chk("R10 net change -3", 32'(tx_level), 1);
    endtask

    task automatic t_flush();
        logic [31:0] g;
        set_mode(1'b1, 1'b1);
        push(1'b0, 32'h55555555, 32);
        push(1'b1, 32'h66666666, 32);
        pop(1'b0, 8, g);
        flush = 1'b1;
        push_req = 1'b1; push_dir = 1'b0; push_word = 32'h77777777; push_wl = 5'd31;
        @(negedge clk);
        flush = 1'b0; push_req = 1'b0;
        chk("R11 tx cleared, push ignored", 32'(tx_level), 0);
        chk("R11 rx cleared", 32'(rx_level), 0);
        push(1'b0, 32'h89ABCDEF, 32);
        pop(1'b0, 32, g);
        chk("R11 data after flush", g, 32'h89ABCDEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_fill_tx();
        t_wrap_both();
        t_partial();
        t_split();
        t_rx_only();
        t_same_cycle();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule